// File: doc/BRIEF.md
# Shared-Counter Watchdog with Offset Reload

This block is a watchdog that shares a 16-bit timer counter, made of a low byte and a high byte, with one compare channel. The counter advances on a clock-enable input. While the watchdog is enabled it owns both the counter and the compare channel. The counter is forced to run and cannot be written. The counter configuration and the compare channel's mode are frozen.

Software keeps the watchdog quiet by writing any value to the compare-high register. That write stores the live counter high byte plus an 8-bit offset register, and the sum wraps. A reset pulse is raised when the low byte rolls over from all ones to zero while the compare-high register equals the counter high byte. This gives a timeout of 256 × offset + 256 − (low byte at the refresh) counter ticks. Writing 1 to the channel's flag bit while the watchdog is enabled forces a reset at once.

When the watchdog is disabled, the counter follows the software run bit. The compare registers are then plain storage, and no reset is produced.

Top module: `ctr_watchdog`

## Requirements
- R1: After reset the watchdog is enabled. MODE (address 0) reads 0x80, and CTRL (address 1), counter low (address 2), counter high (address 3), offset (address 5) and compare-high (address 6) read 0x00. `wdt_rst` is low.
- R2: While enabled, the 16-bit counter {high, low} advances by one for each clock with `tick` high, even when the CTRL run bit (bit 0) is 0. The run bit then reads 0.
- R3: While enabled, writes to the counter low (address 2) and counter high (address 3) registers leave the counter unchanged.
- R4: While enabled, MODE bits 3:1 (clock select) and bit 0 (idle control) ignore writes. Writes to the channel mode register (address 4) are blocked, and that register reads the software-timer code 0x48.
- R5: While enabled, a write of any value to compare-high loads it with (counter high + offset) mod 256.
- R6: While enabled, `wdt_rst` is high for exactly one clock, in the cycle after the tick that takes the low byte from 0xFF to 0x00 while compare-high equals counter high. This happens 256 × offset + 256 − L ticks after a refresh made with the low byte at L.
- R7: Writing CTRL with bit 1 set while enabled drives `wdt_rst` high in the next cycle. The same write while disabled has no effect on `wdt_rst`.
- R8: Writing the run bit to 0 while enabled does not stop the counter. While disabled, the counter advances on `tick` only when the run bit is 1.
- R9: While disabled, compare-high and offset are plain read/write storage. The counter bytes and the channel mode register are writable. No overflow produces `wdt_rst`.
- R10: The watchdog is disabled only by writing MODE bit 7 as 0. Writing it as 1 enables the watchdog again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter clock enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | BYTE_W | Write data |
| rd_data | output | BYTE_W | Read data, combinational from `addr` |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
The timeout is tried with a refresh made part-way through a low byte (L = 0xF0, offset 2) and with a refresh on a byte boundary (L = 0, offset 0). This separates a correct −L term and an off-by-one overflow edge from a design that ignores the low byte or fires one tick early or late. The reload is tried with a high byte that wraps (0xFF + 1) and one that does not, which exposes a carry leaking past eight bits. Each freeze rule is tried by a write in both the enabled and the disabled state, so a lock that is always on or always off shows up. The forced reset and the overflow reset are each compared between the two states.

// File: rtl/wd_pkg.sv
package wd_pkg;
   localparam int ADDR_W = 3;

   // register map
   localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
   localparam logic [ADDR_W-1:0] A_CNTLO  = 3'd2;
   localparam logic [ADDR_W-1:0] A_CNTHI  = 3'd3;
   localparam logic [ADDR_W-1:0] A_CHMODE = 3'd4;
   localparam logic [ADDR_W-1:0] A_OFFS   = 3'd5;
   localparam logic [ADDR_W-1:0] A_CMPHI  = 3'd6;

   // field positions
   localparam int MODE_EN_BIT   = 7;
   localparam int MODE_SEL_LSB  = 1;
   localparam int MODE_SEL_W    = 3;
   localparam int MODE_IDLE_BIT = 0;
   localparam int CTRL_RUN_BIT  = 0;
   localparam int CTRL_FLAG_BIT = 1;
   localparam int CNT_BYTES     = 2;
endpackage

// File: rtl/wd_tick_counter.sv
module wd_tick_counter import wd_pkg::*; #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic [BYTE_W-1:0] ld_val,
   output logic [BYTE_W-1:0] lo,
   output logic [BYTE_W-1:0] hi,
   output logic              lo_wrap
);
   logic [CNT_BYTES-1:0][BYTE_W-1:0] q;
   logic [CNT_BYTES-1:0]             cin;
   logic [CNT_BYTES-1:0]             ld;

   assign ld = {ld_hi, ld_lo};

   for (genvar g = 0; g < CNT_BYTES; g++) begin : g_lane
      if (g == 0) begin : g_first
         assign cin[g] = adv;
      end else begin : g_rest
         assign cin[g] = cin[g-1] && (&q[g-1]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q[g] <= '0;
         else if (ld[g])
            q[g] <= ld_val;
         else if (cin[g])
            q[g] <= q[g] + 1'b1;
      end
   end

   assign lo      = q[0];
   assign hi      = q[CNT_BYTES-1];
   assign lo_wrap = adv && (&q[0]);
endmodule

// File: rtl/wd_cmp_channel.sv
module wd_cmp_channel #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wd_en,
   input  logic              wr_offs,
   input  logic              wr_cmp,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [BYTE_W-1:0] cnt_hi,
   output logic [BYTE_W-1:0] offs_q,
   output logic [BYTE_W-1:0] cmp_q,
   output logic              match
);
   logic [BYTE_W-1:0] reload;

   assign reload = cnt_hi + offs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offs_q <= '0;
         cmp_q  <= '0;
      end else begin
         if (wr_offs)
            offs_q <= wr_data;
         if (wr_cmp)
            cmp_q <= wd_en ? reload : wr_data;
      end
   end

   assign match = (cmp_q == cnt_hi);
endmodule

// File: rtl/ctr_watchdog.sv
module ctr_watchdog import wd_pkg::*; #(
   parameter int                BYTE_W   = 8,
   parameter logic [BYTE_W-1:0] SWT_CODE = 'h48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] rd_data,
   output logic              wdt_rst
);
   if (BYTE_W < 8) begin : g_bad_width
      $error("ctr_watchdog: BYTE_W must be at least 8");
   end

   logic                  wd_en_q, idle_q, run_q, wdt_rst_q;
   logic [MODE_SEL_W-1:0] clk_sel_q;
   logic [BYTE_W-1:0]     chmode_q;
   logic [BYTE_W-1:0]     cnt_lo, cnt_hi, offs_q, cmp_q;
   logic                  lo_wrap, match, adv;
   logic                  wr_mode, wr_ctrl, wr_lo, wr_hi, wr_chm, wr_offs, wr_cmp;
   logic                  force_evt, ovf_evt;

   assign wr_mode = wr_en && (addr == A_MODE);
   assign wr_ctrl = wr_en && (addr == A_CTRL);
   assign wr_lo   = wr_en && (addr == A_CNTLO) && !wd_en_q;
   assign wr_hi   = wr_en && (addr == A_CNTHI) && !wd_en_q;
   assign wr_chm  = wr_en && (addr == A_CHMODE);
   assign wr_offs = wr_en && (addr == A_OFFS);
   assign wr_cmp  = wr_en && (addr == A_CMPHI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_en_q   <= 1'b1;
         clk_sel_q <= '0;
         idle_q    <= 1'b0;
         run_q     <= 1'b0;
         chmode_q  <= '0;
      end else begin
         if (wr_mode) begin
            wd_en_q <= wr_data[MODE_EN_BIT];
            if (!wd_en_q) begin
               clk_sel_q <= wr_data[MODE_SEL_LSB +: MODE_SEL_W];
               idle_q    <= wr_data[MODE_IDLE_BIT];
            end
         end
         if (wr_ctrl)
            run_q <= wr_data[CTRL_RUN_BIT];
         if (wr_chm && !wd_en_q)
            chmode_q <= wr_data;
      end
   end

   assign adv = tick && (run_q || wd_en_q);

   wd_tick_counter #(.BYTE_W(BYTE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .ld_lo(wr_lo), .ld_hi(wr_hi), .ld_val(wr_data),
      .lo(cnt_lo), .hi(cnt_hi), .lo_wrap(lo_wrap)
   );

   wd_cmp_channel #(.BYTE_W(BYTE_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .wd_en(wd_en_q),
      .wr_offs(wr_offs), .wr_cmp(wr_cmp), .wr_data(wr_data),
      .cnt_hi(cnt_hi), .offs_q(offs_q), .cmp_q(cmp_q), .match(match)
   );

   assign force_evt = wd_en_q && wr_ctrl && wr_data[CTRL_FLAG_BIT];
   assign ovf_evt   = wd_en_q && lo_wrap && match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wdt_rst_q <= 1'b0;
      else
         wdt_rst_q <= force_evt || ovf_evt;
   end
   assign wdt_rst = wdt_rst_q;

   always_comb begin
      rd_data = '0;
      case (addr)
         A_MODE: begin
            rd_data[MODE_EN_BIT]                     = wd_en_q;
            rd_data[MODE_SEL_LSB +: MODE_SEL_W]      = clk_sel_q;
            rd_data[MODE_IDLE_BIT]                   = idle_q;
         end
         A_CTRL:   rd_data[CTRL_RUN_BIT] = run_q;
         A_CNTLO:  rd_data = cnt_lo;
         A_CNTHI:  rd_data = cnt_hi;
         A_CHMODE: rd_data = wd_en_q ? SWT_CODE : chmode_q;
         A_OFFS:   rd_data = offs_q;
         A_CMPHI:  rd_data = cmp_q;
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/wd_chk.sv
module wd_chk import wd_pkg::*; #(
   parameter int BYTE_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wd_en,
   input logic                  tick,
   input logic                  wr_en,
   input logic [ADDR_W-1:0]     addr,
   input logic [BYTE_W-1:0]     cnt_lo,
   input logic [BYTE_W-1:0]     cnt_hi,
   input logic [BYTE_W-1:0]     offs,
   input logic [BYTE_W-1:0]     cmp_hi,
   input logic [MODE_SEL_W-1:0] clk_sel,
   input logic                  idle,
   input logic [BYTE_W-1:0]     chmode,
   input logic                  wdt_rst
);
   // R2
   cnt_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_en && tick |=> {cnt_hi, cnt_lo} == (2*BYTE_W)'($past({cnt_hi, cnt_lo}) + 1'b1));

   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_en && !tick |=> $stable(cnt_lo) && $stable(cnt_hi));

   // R4
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_en |=> $stable(clk_sel) && $stable(idle) && $stable(chmode));

   // R5
   refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_en && wr_en && (addr == A_CMPHI) |=> cmp_hi == BYTE_W'($past(cnt_hi) + $past(offs)));

   // R9
   no_rst_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |-> $past(wd_en));
endmodule

bind ctr_watchdog wd_chk #(.BYTE_W(BYTE_W)) u_wd_chk (
   .clk(clk), .rst_n(rst_n), .wd_en(wd_en_q), .tick(tick),
   .wr_en(wr_en), .addr(addr), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
   .offs(offs_q), .cmp_hi(cmp_q), .clk_sel(clk_sel_q), .idle(idle_q),
   .chmode(chmode_q), .wdt_rst(wdt_rst)
);

// File: tb/tb_ctr_watchdog.sv
module tb_ctr_watchdog;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       wdt_rst;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   ctr_watchdog dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .wdt_rst(wdt_rst)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic ticks(input int n);
      repeat (n) begin
         @(negedge clk);
         tick = 1'b1;
      end
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(3'd0, v); check("R1 mode", v, 8'h80);
      rd(3'd1, v); check("R1 ctrl", v, 8'h00);
      rd(3'd2, v); check("R1 cnt lo", v, 8'h00);
      rd(3'd3, v); check("R1 cnt hi", v, 8'h00);
      rd(3'd5, v); check("R1 offset", v, 8'h00);
      rd(3'd6, v); check("R1 cmp hi", v, 8'h00);
      check("R1 wdt_rst", wdt_rst, 0);
   endtask

   task automatic t_forced_run();
      logic [7:0] v;
      wr(3'd1, 8'h00);
      ticks(5);
      rd(3'd2, v); check("R2 forced count", v, 8'h05);
      rd(3'd1, v); check("R2 run reads 0", v, 8'h00);
   endtask

   task automatic t_cnt_locked();
      logic [7:0] v;
      wr(3'd2, 8'h77);
      wr(3'd3, 8'h12);
      rd(3'd2, v); check("R3 lo locked", v, 8'h05);
      rd(3'd3, v); check("R3 hi locked", v, 8'h00);
   endtask

   task automatic t_cfg_locked();
      logic [7:0] v;
      wr(3'd0, 8'h8F);
      rd(3'd0, v); check("R4 mode frozen", v, 8'h80);
      wr(3'd4, 8'h11);
      rd(3'd4, v); check("R4 chmode sw timer", v, 8'h48);
   endtask

   task automatic t_refresh();
      logic [7:0] v;
      wr(3'd0, 8'h00);
      rd(3'd0, v); check("R10 disabled", v, 8'h00);
      wr(3'd3, 8'hFF); wr(3'd2, 8'h10); wr(3'd5, 8'h01);
      wr(3'd0, 8'h80);
      rd(3'd0, v); check("R10 re-enabled", v, 8'h80);
      wr(3'd6, 8'hAA);
      rd(3'd6, v); check("R5 wrap reload", v, 8'h00);
      wr(3'd0, 8'h00);
      wr(3'd3, 8'h30); wr(3'd5, 8'h05);
      wr(3'd0, 8'h80);
      wr(3'd6, 8'h00);
      rd(3'd6, v); check("R5 reload", v, 8'h35);
   endtask

   task automatic timeout_run(input logic [7:0] lo, input logic [7:0] hi,
                              input logic [7:0] off, input int lim, input string req);
      int first = -1;
      int pulses = 0;
      wr(3'd0, 8'h00);
      wr(3'd2, lo); wr(3'd3, hi); wr(3'd5, off);
      wr(3'd0, 8'h80);
      wr(3'd6, 8'h5A);
      @(negedge clk);
      tick = 1'b1;
      for (int n = 1; n <= lim; n++) begin
         @(posedge clk);
         @(negedge clk);
         if (wdt_rst) begin
            pulses++;
            if (first < 0) first = n;
         end
      end
      tick = 1'b0;
      check({req, " timeout ticks"}, first, 256 * off + 256 - lo);
      check({req, " single pulse"}, pulses, 1);
   endtask

   task automatic t_timeout();
      timeout_run(8'hF0, 8'h05, 8'h02, 600, "R6 mid-byte");
      timeout_run(8'h00, 8'h20, 8'h00, 300, "R6 boundary");
   endtask

   task automatic t_force();
      wr(3'd1, 8'h02);
      check("R7 forced reset", wdt_rst, 1);
      @(negedge clk);
      check("R7 pulse ends", wdt_rst, 0);
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h02);
      check("R7 no force when off", wdt_rst, 0);
   endtask

   task automatic t_run_ctrl();
      logic [7:0] v;
      wr(3'd1, 8'h00);
      wr(3'd2, 8'h40); wr(3'd3, 8'h00);
      ticks(3);
      rd(3'd2, v); check("R8 stopped when off", v, 8'h40);
      wr(3'd1, 8'h01);
      ticks(3);
      rd(3'd2, v); check("R8 runs when set", v, 8'h43);
      rd(3'd1, v); check("R8 run reads 1", v, 8'h01);
   endtask

   task automatic t_disabled();
      logic [7:0] v;
      logic       seen = 1'b0;
      rd(3'd4, v); check("R9 chmode kept", v, 8'h00);
      wr(3'd4, 8'h11);
      rd(3'd4, v); check("R9 chmode write", v, 8'h11);
      wr(3'd6, 8'h33);
      rd(3'd6, v); check("R9 cmp storage", v, 8'h33);
      wr(3'd5, 8'h44);
      rd(3'd5, v); check("R9 offset storage", v, 8'h44);
      wr(3'd2, 8'hFF); wr(3'd3, 8'h33);
      @(negedge clk); tick = 1'b1;
      @(posedge clk); @(negedge clk); tick = 1'b0;
      seen = wdt_rst;
      check("R9 no overflow reset", seen, 0);
      rd(3'd3, v); check("R9 hi carried", v, 8'h34);
      rd(3'd2, v); check("R9 lo wrapped", v, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_forced_run();
      t_cnt_locked();
      t_cfg_locked();
      t_refresh();
      t_timeout();
      t_force();
      t_run_ctrl();
      t_disabled();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule